// File: doc/BRIEF.md
# Eight-Channel Two-Step Input Deglitch Filter

This block cleans up eight raw digital levels, such as comparator outputs from field inputs, before they are stored as the registered input states. A channel takes on a new level only after that level has been seen on a run of consecutive filter ticks. A single sample of the old level during the run throws the run away. The filtered states and a one-cycle change strobe are the outputs.

The filtering happens in two steps. The first step synchronizes every raw input to the filter clock through a short flop chain, and a prescaler turns that clock into a periodic tick that marks when a sample is taken. The second step is a run counter for each channel. The run length is a power of two chosen by a 4-bit delay code, so one code spans short and long filter times. With a tick period of 20 µs, code 0 gives 20 µs, code 8 gives about 5 ms, and the largest code gives much longer times.

Top module: `fdf_deglitch8`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every filtered state bit is 0 and the update strobe is 0.
- R2: A channel whose synchronized input differs from its filtered state on N = 2^code consecutive ticks takes the new level at the Nth tick. Here code is the unsigned value of `dly_sel`. This applies to both rising and falling changes.
- R3: A filtered state bit changes only in the cycle right after a tick. After a raw change, no update appears within (N-1)*PRESC_DIV+2 clock cycles. The change has appeared after N*PRESC_DIV+3 cycles.
- R4: A tick that samples a level equal to the current filtered state sets the run back to zero. A pulse seen on fewer than N ticks leaves the state unchanged. A later run has to collect all N ticks again.
- R5: Each channel filters on its own. Bit i of `filt_q` depends only on bit i of `raw_in`.
- R6: `upd_stb` is high for exactly those cycles in which `filt_q` differs from its value in the previous cycle.
- R7: A tick occurs once every PRESC_DIV clock cycles. When PRESC_DIV is greater than 1, two ticks never fall in adjacent cycles.
- R8: Delay code 0 gives a one-tick filter, so a change held for at least one tick is passed on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | NCH | Unfiltered channel levels |
| dly_sel | input | CODE_W | Delay code; run length is 2^code ticks |
| filt_q | output | NCH | Filtered channel states |
| upd_stb | output | 1 | One-cycle pulse when any filtered bit changes |

## Verification
The bench uses clean steps, both rising and falling, and checks them against a lower and an upper cycle bound. This separates a correct run length from one that is off by a tick or ignores the delay code. Pulses shorter than the run length show whether glitches are rejected. A run broken by a dip of two ticks shows whether the counter really restarts or only pauses. Single-channel and mixed multi-channel patterns expose crosstalk between channels, and a code-0 step covers the shortest filter. A monitor running every cycle compares the strobe with the observed state changes.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
   // Widest delay code the run counter is sized for.
   localparam int unsigned FDF_MAX_CODE_W = 5;

   // Number of consecutive ticks required for a given delay code.
   function automatic int unsigned fdf_run_ticks(input int unsigned code);
      return 32'd1 << code;
   endfunction
endpackage

// File: rtl/fdf_tick_gen.sv
module fdf_tick_gen #(
   parameter int unsigned PRESC_DIV = 40
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (PRESC_DIV == 1) begin : g_every_cycle
         assign tick = 1'b1;
      end else begin : g_divider
         localparam int unsigned PC_W = $clog2(PRESC_DIV);
         localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRESC_DIV - 1);
         logic [PC_W-1:0] pc;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             pc <= '0;
            else if (pc == PC_LAST) pc <= '0;
            else                    pc <= pc + 1'b1;
         end

         assign tick = (pc == PC_LAST);
      end
   endgenerate
endmodule

// File: rtl/fdf_sync_stage.sv
module fdf_sync_stage #(
   parameter int unsigned NCH   = 8,
   parameter int unsigned DEPTH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] d,
   output logic [NCH-1:0] q
);
   logic [NCH-1:0] chain [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[DEPTH-1];
endmodule

// File: rtl/fdf_run_counter.sv
module fdf_run_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         smp,
   input  logic [CNT_W:0] need,
   output logic         state,
   output logic         commit
);
   logic [CNT_W-1:0] run;
   logic [CNT_W:0]   run_next;

   assign run_next = {1'b0, run} + 1'b1;
   assign commit   = tick && (smp != state) && (run_next >= need);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= '0;
         state <= 1'b0;
      end else if (tick) begin
         if (smp == state) begin
            run <= '0;
         end else if (commit) begin
            run   <= '0;
            state <= smp;
         end else begin
            run <= run_next[CNT_W-1:0];
         end
      end
   end
endmodule

// File: rtl/fdf_deglitch8.sv
module fdf_deglitch8 #(
   parameter int unsigned NCH         = 8,
   parameter int unsigned CODE_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PRESC_DIV   = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    raw_in,
   input  logic [CODE_W-1:0] dly_sel,
   output logic [NCH-1:0]    filt_q,
   output logic              upd_stb
);
   localparam int unsigned CNT_W = 2 ** CODE_W;

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("NCH must be at least 1");
      end
      if (CODE_W < 1 || CODE_W > fdf_pkg::FDF_MAX_CODE_W) begin : g_bad_code
         $error("CODE_W out of supported range");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (PRESC_DIV < 1) begin : g_bad_div
         $error("PRESC_DIV must be at least 1");
      end
   endgenerate

   logic           tick_w;
   logic [NCH-1:0] sync_w;
   logic [NCH-1:0] commit_w;
   logic [CNT_W:0] need_w;

   assign need_w = (CNT_W+1)'(fdf_pkg::fdf_run_ticks(32'(dly_sel)));

   fdf_tick_gen #(.PRESC_DIV(PRESC_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_w)
   );

   fdf_sync_stage #(.NCH(NCH), .DEPTH(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_w)
   );

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
         fdf_run_counter #(.CNT_W(CNT_W)) u_run (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_w),
            .smp    (sync_w[ch]),
            .need   (need_w),
            .state  (filt_q[ch]),
            .commit (commit_w[ch])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_stb <= 1'b0;
      else        upd_stb <= |commit_w;
   end
endmodule

// File: rtl/fdf_deglitch8_chk.sv
module fdf_deglitch8_chk #(
   parameter int unsigned NCH       = 8,
   parameter int unsigned PRESC_DIV = 40
) (
   input logic           clk,
   input logic           rst_n,
   input logic           tick,
   input logic [NCH-1:0] filt_q,
   input logic           upd_stb
);
   // R1: reset leaves states and strobe cleared
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (filt_q == '0 && !upd_stb));

   // R3: state bits move only on the cycle after a tick
   p_change_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_q != $past(filt_q)) |-> $past(tick));

   // R6: strobe marks every change and nothing else
   p_strobe_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb == (filt_q != $past(filt_q)));

   // R6: strobe lasts a single cycle per change
   p_strobe_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |-> $countones(filt_q ^ $past(filt_q)) >= 1);

   generate
      if (PRESC_DIV > 1) begin : g_tick_chk
         // R7: ticks never come back to back
         p_tick_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

bind fdf_deglitch8 fdf_deglitch8_chk #(.NCH(NCH), .PRESC_DIV(PRESC_DIV)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick_w),
   .filt_q  (filt_q),
   .upd_stb (upd_stb)
);

// File: tb/tb_fdf_deglitch8.sv
module tb_fdf_deglitch8;
   localparam int unsigned DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] raw_in = '0;
   logic [3:0] dly_sel = '0;
   logic [7:0] filt_q;
   logic       upd_stb;

   int errs = 0;
   int checks = 0;
   int strb_errs = 0;
   bit mon_on = 1'b0;
   logic [7:0] prev_q = '0;

   always #4 clk = ~clk;

   fdf_deglitch8 #(.NCH(8), .CODE_W(4), .SYNC_STAGES(2), .PRESC_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .dly_sel(dly_sel),
      .filt_q(filt_q), .upd_stb(upd_stb)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R6 monitor: strobe high exactly when the filtered state moved
   always @(negedge clk) begin
      if (mon_on && (upd_stb !== (filt_q != prev_q))) strb_errs++;
      prev_q <= filt_q;
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      wait_cyc(3);
      chk("R1 state in reset", filt_q, 8'h00);
      chk("R1 strobe in reset", {7'd0, upd_stb}, 8'h00);
      rst_n = 1'b1;
      wait_cyc(1);
      chk("R1 state after release", filt_q, 8'h00);
      mon_on = 1'b1;
   endtask

   // step then check lower and upper latency bounds
   task automatic step_bounds(input string tag, input logic [7:0] nv, input logic [7:0] oldv, input int n);
      raw_in = nv;
      wait_cyc((n-1)*DIV + 2);
      chk({tag, " not early"}, filt_q, oldv);
      wait_cyc(n*DIV + 3 - ((n-1)*DIV + 2));
      chk({tag, " arrived"}, filt_q, nv);
   endtask

   task automatic t_rise_fall;
      dly_sel = 4'd2;
      step_bounds("R2 R3 rise code2", 8'h01, 8'h00, 4);
      step_bounds("R2 R3 fall code2", 8'h00, 8'h01, 4);
   endtask

   task automatic t_glitch;
      dly_sel = 4'd2;
      raw_in = 8'h02;
      wait_cyc(2*DIV);
      raw_in = 8'h00;
      wait_cyc(6*DIV);
      chk("R4 short pulse rejected", filt_q, 8'h00);
   endtask

   task automatic t_restart;
      dly_sel = 4'd2;
      raw_in = 8'h04;
      wait_cyc(3*DIV);
      raw_in = 8'h00;
      wait_cyc(2*DIV);
      chk("R4 no commit before dip", filt_q, 8'h00);
      step_bounds("R4 full run after dip", 8'h04, 8'h00, 4);
      raw_in = 8'h00;
      wait_cyc(4*DIV + 3);
      chk("R4 cleared", filt_q, 8'h00);
   endtask

   task automatic t_independent;
      dly_sel = 4'd1;
      step_bounds("R5 single channel", 8'h08, 8'h00, 2);
      step_bounds("R5 mixed channels", 8'hA5, 8'h08, 2);
      step_bounds("R5 inverted pattern", 8'h5A, 8'hA5, 2);
   endtask

   task automatic t_code_zero;
      dly_sel = 4'd0;
      step_bounds("R8 code0 rise", 8'hFF, 8'h5A, 1);
      step_bounds("R8 code0 fall", 8'h00, 8'hFF, 1);
   endtask

   initial begin
      t_reset;
      t_rise_fall;
      t_glitch;
      t_restart;
      t_independent;
      t_code_zero;
      checks++;
      if (strb_errs != 0) begin
         errs++;
         $display("FAIL R6 strobe mismatches actual=%0d expected=0", strb_errs);
      end
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule